// File: doc/BRIEF.md
# Multi-lane PHY control and status register bank

This block is the word-addressed register slave for a multi-lane Ethernet PCS/PMA. Software on a status clock reads identification words and a scratch word, drives configuration and soft-reset bits into the lane logic, reads per-lane PLL and CDR lock status, and samples per-lane FIFO flags through an indirect select register. The bus is a plain address with read and write strobes, 32-bit write data and registered 32-bit read data.

Frame-error status is kept per virtual lane. A lane's bit is set by an event pulse from the alignment logic and stays set until software clears it. Clearing is done with a write-1 level: the clear bit does not return to 0 by itself, and for as long as it stays at 1 the whole status word is held at zero. A parameter decides whether the high bit-error-rate indication is passed through or forced to zero.

Top module: `phy_csr_bank`

## Requirements
- R1: Address 0x00 reads the fixed revision word 0x02062015. Addresses 0x02, 0x03 and 0x04 read the 12-character variant name, four ASCII characters each, first character in bits [31:24] of 0x02. Writes to these addresses change nothing.
- R2: Address 0x01 is a 32-bit read/write scratch word that resets to zero.
- R3: Address 0x08 holds six configuration bits that reset to zero, read back in [5:0] and drive outputs: bit 0 system reset start, bit 1 TX PLL soft reset, bit 2 RX PLL soft reset, bit 3 skip CDR lock wait, bit 4 lock to reference, bit 5 lock to data. They change only when 0x08 is written.
- R4: Address 0x0A is a 3-bit FIFO flag select that resets to 000. Code k selects flag k: 000 TX full, 001 TX empty, 010 TX partial full, 011 TX partial empty, 100 RX full, 101 RX empty, 110 RX partial full, 111 RX partial empty. Flag k of lane n enters on fifo_flags bit k*LANES+n.
- R5: Address 0x0B reads, in bit n, the selected flag of lane n, with LANES valid bits and zeros above.
- R6: Address 0x10 reads the frame-error status, one bit per virtual lane, all ones after reset. Bit v becomes 1 on the cycle after frame_err_event[v] is high and stays 1. Writes to 0x10 are ignored.
- R7: Address 0x11 bit 0 is the frame-error clear. It resets to 0 and never clears itself. On every cycle after one in which it is 1, the frame-error status is all zeros, even while events arrive.
- R8: Address 0x12 holds two soft-reset bits that reset to 00 and never clear themselves: bit 0 resets the RX PCS, bit 1 clears the RX FIFO. They change only when 0x12 is written.
- R9: Address 0x13 reads bit 0 as RX PCS aligned and bit 1 as high bit error rate. Bit 1 is 0 whenever LINK_FAULT_EN is 0.
- R10: Addresses 0x0C and 0x0D read the per-lane TX PLL lock and RX CDR lock inputs, lane n in bit n.
- R11: A read of any other address returns zero, and writes to any address other than 0x01, 0x08, 0x0A, 0x11 and 0x12 change no register.
- R12: Read data appears on the clock edge that samples rd, reflects register state from before any write in that cycle, and is zero after a cycle without rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Status clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| fifo_flags | input | 8*LANES | Per-lane FIFO flags, flag k of lane n at bit k*LANES+n |
| tx_pll_lock | input | LANES | Per-lane TX PLL lock |
| cdr_lock | input | LANES | Per-lane RX CDR lock |
| frame_err_event | input | VLANES | Per-virtual-lane frame-error pulses |
| rx_aligned | input | 1 | RX PCS fully aligned |
| rx_hi_ber | input | 1 | RX high bit error rate |
| cfg_sys_rst | output | 1 | Start system reset sequence |
| cfg_txpll_rst | output | 1 | TX PLL soft reset |
| cfg_rxpll_rst | output | 1 | RX PLL soft reset |
| cfg_skip_cdr | output | 1 | Proceed without CDR lock |
| cfg_ref_lock | output | 1 | Lock PLL to reference |
| cfg_data_lock | output | 1 | Lock PLL to data |
| rxpcs_rst | output | 1 | RX PCS soft reset |
| rxfifo_clr | output | 1 | RX FIFO clear |

## Verification
The bench builds two copies side by side on the same bus: one with the defaults (four lanes, four virtual lanes, high-BER indication masked) and one with twenty virtual lanes and the high-BER indication enabled. The first shows the mask holding bit 1 at zero against a live input; the second shows it passing through and exercises a frame-error word wide enough that stale upper bits would show. Both copies are compared every cycle against a behavioural model while all eight flag selects, write-1 clears held across event bursts, writes to read-only and unmapped addresses, and a long random bus phase are driven.

// File: rtl/phy_csr_bank.sv
module phy_csr_bank #(
  parameter int          LANES         = 4,
  parameter int          VLANES        = 4,
  parameter int          AW            = 8,
  parameter bit          LINK_FAULT_EN = 1'b0,
  parameter logic [31:0] REV_WORD      = 32'h0206_2015,
  parameter logic [95:0] NAME          = "xlg pcs lane"
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              rd,
  output logic [31:0]       rdata,
  input  logic [8*LANES-1:0] fifo_flags,
  input  logic [LANES-1:0]  tx_pll_lock,
  input  logic [LANES-1:0]  cdr_lock,
  input  logic [VLANES-1:0] frame_err_event,
  input  logic              rx_aligned,
  input  logic              rx_hi_ber,
  output logic              cfg_sys_rst,
  output logic              cfg_txpll_rst,
  output logic              cfg_rxpll_rst,
  output logic              cfg_skip_cdr,
  output logic              cfg_ref_lock,
  output logic              cfg_data_lock,
  output logic              rxpcs_rst,
  output logic              rxfifo_clr
);

  localparam logic [AW-1:0] A_REV   = AW'('h00);
  localparam logic [AW-1:0] A_SCR   = AW'('h01);
  localparam logic [AW-1:0] A_NAME0 = AW'('h02);
  localparam logic [AW-1:0] A_NAME1 = AW'('h03);
  localparam logic [AW-1:0] A_NAME2 = AW'('h04);
  localparam logic [AW-1:0] A_CFG   = AW'('h08);
  localparam logic [AW-1:0] A_SEL   = AW'('h0A);
  localparam logic [AW-1:0] A_FLAG  = AW'('h0B);
  localparam logic [AW-1:0] A_TXLK  = AW'('h0C);
  localparam logic [AW-1:0] A_CDRLK = AW'('h0D);
  localparam logic [AW-1:0] A_FERR  = AW'('h10);
  localparam logic [AW-1:0] A_FCLR  = AW'('h11);
  localparam logic [AW-1:0] A_SRST  = AW'('h12);
  localparam logic [AW-1:0] A_STAT  = AW'('h13);

  logic [31:0]       scratch_q;
  logic [5:0]        cfg_q;
  logic [2:0]        sel_q;
  logic [1:0]        srst_q;
  logic              fe_clr_q;
  logic [VLANES-1:0] fe_q;
  logic [LANES-1:0]  flag_lanes;
  logic [1:0]        pcs_stat;
  logic [31:0]       rmux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_q <= '0;
      cfg_q     <= '0;
      sel_q     <= '0;
      srst_q    <= '0;
      fe_clr_q  <= 1'b0;
    end else if (wr) begin
      if (addr == A_SCR)  scratch_q <= wdata;
      if (addr == A_CFG)  cfg_q     <= wdata[5:0];
      if (addr == A_SEL)  sel_q     <= wdata[2:0];
      if (addr == A_SRST) srst_q    <= wdata[1:0];
      if (addr == A_FCLR) fe_clr_q  <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fe_q <= '1;
    else if (fe_clr_q) fe_q <= '0;
    else               fe_q <= fe_q | frame_err_event;
  end

  assign flag_lanes = fifo_flags[32'(sel_q)*LANES +: LANES];
  assign pcs_stat   = {LINK_FAULT_EN & rx_hi_ber, rx_aligned};

  always_comb begin
    case (addr)
      A_REV:   rmux = REV_WORD;
      A_SCR:   rmux = scratch_q;
      A_NAME0: rmux = NAME[95:64];
      A_NAME1: rmux = NAME[63:32];
      A_NAME2: rmux = NAME[31:0];
      A_CFG:   rmux = 32'(cfg_q);
      A_SEL:   rmux = 32'(sel_q);
      A_FLAG:  rmux = 32'(flag_lanes);
      A_TXLK:  rmux = 32'(tx_pll_lock);
      A_CDRLK: rmux = 32'(cdr_lock);
      A_FERR:  rmux = 32'(fe_q);
      A_FCLR:  rmux = 32'(fe_clr_q);
      A_SRST:  rmux = 32'(srst_q);
      A_STAT:  rmux = 32'(pcs_stat);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rmux : '0;
  end

  assign {cfg_data_lock, cfg_ref_lock, cfg_skip_cdr,
          cfg_rxpll_rst, cfg_txpll_rst, cfg_sys_rst} = cfg_q;
  assign {rxfifo_clr, rxpcs_rst} = srst_q;

endmodule

// File: rtl/phy_csr_bank_chk.sv
module phy_csr_bank_chk #(
  parameter int VLANES        = 4,
  parameter int AW            = 8,
  parameter bit LINK_FAULT_EN = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     addr,
  input logic              wr,
  input logic              rd,
  input logic [31:0]       rdata,
  input logic [5:0]        cfg_q,
  input logic [1:0]        srst_q,
  input logic              fe_clr_q,
  input logic [VLANES-1:0] fe_q
);

  assert_rev_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == AW'('h00)) |=> rdata == 32'h0206_2015);

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == AW'('h08)) |=> $stable(cfg_q));

  assert_fe_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fe_clr_q |=> fe_q == '0);

  assert_srst_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == AW'('h12)) |=> $stable(srst_q));

  assert_ber_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!LINK_FAULT_EN && rd && addr == AW'('h13)) |=> rdata[1] == 1'b0);

  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> rdata == '0);

endmodule

bind phy_csr_bank phy_csr_bank_chk #(
  .VLANES(VLANES), .AW(AW), .LINK_FAULT_EN(LINK_FAULT_EN)
) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .rdata(rdata),
  .cfg_q(cfg_q), .srst_q(srst_q), .fe_clr_q(fe_clr_q), .fe_q(fe_q)
);

// File: tb/phy_csr_bank_tb_top.sv
`timescale 1ns/1ps
module phy_csr_bank_tb_top;
  localparam int LN = 4;
  localparam int VA = 4;
  localparam int VB = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [8*LN-1:0] fifo_flags = '0;
  logic [LN-1:0] txlk = '0, cdrlk = '0;
  logic [VA-1:0] fe_a = '0;
  logic [VB-1:0] fe_b = '0;
  logic aligned = 1'b0, hiber = 1'b0;
  logic [31:0] rdata_a, rdata_b;
  logic [5:0] cfg_o, cfg_unused_b;
  logic [1:0] srst_o, srst_unused_b;

  phy_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rd(rd),
    .rdata(rdata_a), .fifo_flags(fifo_flags), .tx_pll_lock(txlk),
    .cdr_lock(cdrlk), .frame_err_event(fe_a), .rx_aligned(aligned),
    .rx_hi_ber(hiber), .cfg_sys_rst(cfg_o[0]), .cfg_txpll_rst(cfg_o[1]),
    .cfg_rxpll_rst(cfg_o[2]), .cfg_skip_cdr(cfg_o[3]), .cfg_ref_lock(cfg_o[4]),
    .cfg_data_lock(cfg_o[5]), .rxpcs_rst(srst_o[0]), .rxfifo_clr(srst_o[1]));

  phy_csr_bank #(.VLANES(VB), .LINK_FAULT_EN(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .wdata(wdata), .rd(rd),
    .rdata(rdata_b), .fifo_flags(fifo_flags), .tx_pll_lock(txlk),
    .cdr_lock(cdrlk), .frame_err_event(fe_b), .rx_aligned(aligned),
    .rx_hi_ber(hiber), .cfg_sys_rst(cfg_unused_b[0]),
    .cfg_txpll_rst(cfg_unused_b[1]), .cfg_rxpll_rst(cfg_unused_b[2]),
    .cfg_skip_cdr(cfg_unused_b[3]), .cfg_ref_lock(cfg_unused_b[4]),
    .cfg_data_lock(cfg_unused_b[5]), .rxpcs_rst(srst_unused_b[0]),
    .rxfifo_clr(srst_unused_b[1]));

  int n_chk = 0, n_fail = 0;

  // reference model state
  logic [31:0] m_scr;
  logic [5:0]  m_cfg;
  logic [2:0]  m_sel;
  logic [1:0]  m_srst;
  logic        m_clr;
  logic [VA-1:0] m_fea;
  logic [VB-1:0] m_feb;
  logic [31:0] exp_a = '0, exp_b = '0;
  logic [7:0]  last_addr = '0;
  bit          started = 0;

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h02, 8'h03, 8'h04: return "R1";
      8'h01: return "R2";
      8'h08: return "R3";
      8'h0A: return "R4";
      8'h0B: return "R5";
      8'h0C, 8'h0D: return "R10";
      8'h10: return "R6";
      8'h11: return "R7";
      8'h12: return "R8";
      8'h13: return "R9";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a, input logic [31:0] fe,
                                             input bit lfe);
    logic [31:0] v = '0;
    case (a)
      8'h00: v = 32'h0206_2015;
      8'h01: v = m_scr;
      8'h02: v = "xlg ";
      8'h03: v = "pcs ";
      8'h04: v = "lane";
      8'h08: v = {26'd0, m_cfg};
      8'h0A: v = {29'd0, m_sel};
      8'h0B: for (int n = 0; n < LN; n++) v[n] = fifo_flags[int'(m_sel)*LN + n];
      8'h0C: v = {28'd0, txlk};
      8'h0D: v = {28'd0, cdrlk};
      8'h10: v = fe;
      8'h11: v = {31'd0, m_clr};
      8'h12: v = {30'd0, m_srst};
      8'h13: v = {30'd0, lfe ? hiber : 1'b0, aligned};
      default: v = '0;
    endcase
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_scr = '0; m_cfg = '0; m_sel = '0; m_srst = '0; m_clr = 1'b0;
      m_fea = '1; m_feb = '1; exp_a = '0; exp_b = '0;
    end else begin
      started = 1;
      last_addr = addr;
      exp_a = rd ? model_read(addr, 32'(m_fea), 1'b0) : '0;
      exp_b = rd ? model_read(addr, 32'(m_feb), 1'b1) : '0;
      for (int v = 0; v < VA; v++) m_fea[v] = m_clr ? 1'b0 : (m_fea[v] | fe_a[v]);
      for (int v = 0; v < VB; v++) m_feb[v] = m_clr ? 1'b0 : (m_feb[v] | fe_b[v]);
      if (wr) begin
        case (addr)
          8'h01: m_scr = wdata;
          8'h08: m_cfg = wdata[5:0];
          8'h0A: m_sel = wdata[2:0];
          8'h11: m_clr = wdata[0];
          8'h12: m_srst = wdata[1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // cycle-by-cycle comparison; read tags follow the address, R12 for idle cycles
  always @(negedge clk) begin
    if (started) begin
      check(rdata_a == exp_a, (exp_a == 0 && rdata_a != 0) ? "R12" : req_of(last_addr),
            "rdata (masked copy)", rdata_a, exp_a);
      check(rdata_b == exp_b, req_of(last_addr), "rdata (wide copy)", rdata_b, exp_b);
      check(cfg_o == m_cfg, "R3", "config outputs", 32'(cfg_o), 32'(m_cfg));
      check(srst_o == m_srst, "R8", "soft reset outputs", 32'(srst_o), 32'(m_srst));
    end
  end

  task automatic shake(input bit burst_fe);
    fifo_flags = $urandom;
    txlk = 4'($urandom);
    cdrlk = 4'($urandom);
    aligned = 1'($urandom);
    hiber = 1'($urandom);
    fe_a = burst_fe ? 4'($urandom) & 4'($urandom) : '0;
    fe_b = burst_fe ? 20'($urandom) & 20'($urandom) : '0;
  endtask

  task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                     input logic [31:0] d, input bit burst_fe);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d;
    shake(burst_fe);
  endtask

  task automatic idle(); cyc(0, 0, 8'h00, '0, 0); endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rd = 1'b1; addr = 8'h00;
    repeat (3) @(negedge clk);
    // R12: reads under reset yield nothing
    check(rdata_a == 0, "R12", "rdata under reset", rdata_a, 0);
    rst_n = 1'b1;
    rd = 1'b0;
    idle();
    // reset state and full address sweep (R1, R2, R6, R11)
    for (int a = 0; a < 32; a++) cyc(0, 1, 8'(a), '0, 0);
    cyc(0, 1, 8'hFF, '0, 0);
    // writes of all ones everywhere, read-only and unmapped included (R11)
    for (int a = 0; a < 32; a++) cyc(1, 0, 8'(a), 32'hFFFF_FFFF, 0);
    cyc(1, 0, 8'hFF, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 8'h11, 32'h0, 0);
    for (int a = 0; a < 32; a++) cyc(0, 1, 8'(a), '0, 0);
    // read and write in the same cycle returns old value (R12)
    cyc(1, 1, 8'h01, 32'h1234_5678, 0);
    cyc(1, 1, 8'h01, 32'hA5A5_0F0F, 0);
    cyc(0, 1, 8'h01, '0, 0);
    // config bits one at a time (R3) and soft reset codes (R8)
    for (int b = 0; b < 6; b++) begin
      cyc(1, 0, 8'h08, 32'(1) << b, 0);
      cyc(0, 1, 8'h08, '0, 0);
    end
    for (int c = 0; c < 4; c++) begin
      cyc(1, 0, 8'h12, 32'(c), 0);
      idle(); idle();
      cyc(0, 1, 8'h12, '0, 0);
    end
    // every flag select with several flag patterns (R4, R5)
    for (int s = 0; s < 8; s++) begin
      cyc(1, 0, 8'h0A, 32'(s) | 32'hFFFF_FFF8, 0);
      for (int k = 0; k < 4; k++) cyc(0, 1, 8'h0B, '0, 0);
      cyc(0, 1, 8'h0A, '0, 0);
    end
    // frame errors: clear held while events keep arriving (R6, R7)
    cyc(1, 0, 8'h11, 32'h1, 0);
    for (int k = 0; k < 6; k++) cyc(0, 1, 8'h10, '0, 1);
    cyc(1, 0, 8'h11, 32'h0, 1);
    for (int k = 0; k < 8; k++) cyc(0, 1, 8'h10, '0, k % 2 == 0);
    cyc(1, 0, 8'h10, 32'h0, 0);
    cyc(0, 1, 8'h10, '0, 0);
    // status with high BER toggling on both copies (R9), lock words (R10)
    for (int k = 0; k < 8; k++) cyc(0, 1, (k % 2 == 0) ? 8'h13 : 8'h0C + 8'(k % 4 == 1), '0, 0);
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [7:0] a;
      a = 8'($urandom_range(0, 21));
      if ($urandom_range(0, 15) == 0) a = 8'($urandom);
      cyc(($urandom_range(0, 3) == 0), ($urandom_range(0, 2) != 0), a,
          ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 1)) : $urandom,
          ($urandom_range(0, 1) == 0));
    end
    idle(); idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule